// File: doc/BRIEF.md
# Inverting-Operand Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic-logic unit for the execute stage of a simple processor pipeline. A 4-bit control word selects the operation. The control word is not a flat opcode. Two of its bits optionally complement each operand, and a 2-bit selector picks one of four result sources: bitwise AND, bitwise OR, the adder sum, or a signed less-than bit.

The six operations a processor needs come from combinations of these fields. Subtraction is addition with the second operand complemented and a carry-in of one. NOR is AND with both operands complemented. The unit also drives two flags. The zero flag reports an all-zero result and serves branch-on-equal decisions. The overflow flag reports two's-complement overflow of an addition or subtraction.

Top module: `inv_alu`

## Requirements
- R1: `ctrl_i[3]` complements operand A, `ctrl_i[2]` complements operand B, and `ctrl_i[1:0]` selects the result source: 00 bitwise AND, 01 bitwise OR, 10 adder sum, 11 less-than bit. The adder carry-in equals `ctrl_i[2]`.
- R2: Code 0000 yields A AND B, and code 0001 yields A OR B.
- R3: Code 0010 yields A + B modulo 2^32.
- R4: Code 0110 yields A - B modulo 2^32.
- R5: Code 0111 yields 1 when A < B as signed 32-bit values and 0 otherwise, with bits 31..1 always 0. The result stays correct when the internal subtraction overflows.
- R6: Code 1100 yields NOT (A OR B).
- R7: `zero_o` is 1 exactly when all 32 result bits are 0, for every control code.
- R8: `ovf_o` is 1 only when the selector is 10 and the adder operands after inversion have equal signs while the sum sign differs. It is 0 for every other selector, including the less-than selector.
- R9: Control codes not listed above follow the decomposition of R1. For example, 0100 gives A AND NOT B, 1101 gives NOT A OR NOT B, and 1010 gives NOT A + B with carry-in 0. In general the less-than bit is the adder sum sign XOR the adder overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | Control word: invert A, invert B, 2-bit selector |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of add/subtract |

## Verification
Each of the six named codes is applied to hand-picked operands. Addition and subtraction use pairs at the signed limits, where overflow must and must not be raised. The less-than code uses pairs whose subtraction overflows, so a plain sign-bit compare would give the wrong answer. Equal, opposite-sign and all-ones operands separate the zero flag from the carry and overflow paths. Random operands across all sixteen codes, checked against a model built from the field decomposition, show that the two invert bits and the carry-in act independently of the selector.

// File: rtl/alu_inv_pkg.sv
package alu_inv_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    alu_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign x_o[i] = a_i[i] ^ inv_a_i;
    assign y_o[i] = b_i[i] ^ inv_b_i;
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);

  assign and_o = x_i & y_i;
  assign or_o  = x_i | y_i;

endmodule

// File: rtl/alu_prefix_adder.sv
// Parallel-prefix (log-depth) adder with signed overflow from top carries.
module alu_prefix_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);

  localparam int LVL = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] gen [LVL+1];
  logic [WIDTH-1:0] prp [LVL];
  logic [WIDTH:0]   cry;

  assign prp[0] = x_i ^ y_i;
  // carry-in folded into bit 0 generate
  assign gen[0][0] = (x_i[0] & y_i[0]) | (prp[0][0] & cin_i);
  if (WIDTH > 1) begin : g_gen0
    assign gen[0][WIDTH-1:1] = x_i[WIDTH-1:1] & y_i[WIDTH-1:1];
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int SPAN = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SPAN) begin : g_merge
        assign gen[l+1][i] = gen[l][i] | (prp[l][i] & gen[l][i-SPAN]);
        if (l + 1 < LVL) begin : g_p
          assign prp[l+1][i] = prp[l][i] & prp[l][i-SPAN];
        end
      end else begin : g_pass
        assign gen[l+1][i] = gen[l][i];
        if (l + 1 < LVL) begin : g_p
          assign prp[l+1][i] = prp[l][i];
        end
      end
    end
  end

  assign cry[0] = cin_i;
  assign cry[WIDTH:1] = gen[LVL];

  assign sum_o = prp[0] ^ cry[WIDTH-1:0];
  assign ovf_o = cry[MSB] ^ cry[MSB+1];

endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import alu_inv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctl;
  logic [WIDTH-1:0] x, y, and_r, or_r, sum_r;
  logic             add_ovf, less;

  assign ctl = alu_ctrl_t'(ctrl_i);

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .a_i(a_i), .b_i(b_i), .inv_a_i(ctl.inv_a), .inv_b_i(ctl.inv_b),
    .x_o(x), .y_o(y)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .x_i(x), .y_i(y), .and_o(and_r), .or_o(or_r)
  );

  alu_prefix_adder #(.WIDTH(WIDTH)) u_add (
    .x_i(x), .y_i(y), .cin_i(ctl.inv_b), .sum_o(sum_r), .ovf_o(add_ovf)
  );

  // overflow-corrected sign gives true signed compare
  assign less = sum_r[MSB] ^ add_ovf;

  always_comb begin
    unique case (ctl.sel)
      SEL_AND:  result_o = and_r;
      SEL_OR:   result_o = or_r;
      SEL_SUM:  result_o = sum_r;
      default:  result_o = {{(WIDTH-1){1'b0}}, less};
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = add_ovf & (ctl.sel == SEL_SUM);

endmodule

// File: rtl/inv_alu_chk.sv
module inv_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       ctrl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);

  always_comb begin
    if (!$isunknown({a_i, b_i, ctrl_i})) begin
      a_r2_and: assert (ctrl_i != 4'b0000 || result_o == (a_i & b_i));
      a_r2_or: assert (ctrl_i != 4'b0001 || result_o == (a_i | b_i));
      a_r3_add: assert (ctrl_i != 4'b0010 || result_o == a_i + b_i);
      a_r4_sub: assert (ctrl_i != 4'b0110 || result_o == a_i - b_i);
      a_r5_slt_bit: assert (ctrl_i[1:0] != 2'b11 || result_o[WIDTH-1:1] == '0);
      a_r5_slt_val: assert (ctrl_i != 4'b0111 || result_o[0] == ($signed(a_i) < $signed(b_i)));
      a_r6_nor: assert (ctrl_i != 4'b1100 || result_o == ~(a_i | b_i));
      a_r7_zero_eq: assert (ctrl_i != 4'b0110 || zero_o == (a_i == b_i));
      a_r8_no_overflow: assert (ctrl_i[1:0] == 2'b10 || !ovf_o);
    end
  end

endmodule

bind inv_alu inv_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .ctrl_i(ctrl_i),
  .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/inv_alu_test.sv
module inv_alu_test;

  logic        clk = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [3:0]  ctrl = '0;
  logic [31:0] res;
  logic        zero, ovf;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  inv_alu #(.WIDTH(32)) uut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ctrl=%b a=%h b=%h actual=%h expected=%h", req, ctrl, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] av, input logic [31:0] bv);
    @(negedge clk);
    ctrl = c; a = av; b = bv;
    #2;
  endtask

  // model from the field decomposition
  task automatic model(input logic [3:0] c, input logic [31:0] av, input logic [31:0] bv,
                       output logic [31:0] r, output logic z, output logic o);
    logic [31:0] x, y, s;
    logic        v;
    x = c[3] ? ~av : av;
    y = c[2] ? ~bv : bv;
    s = x + y + {31'd0, c[2]};
    v = (x[31] == y[31]) && (s[31] != x[31]);
    case (c[1:0])
      2'b00: r = x & y;
      2'b01: r = x | y;
      2'b10: r = s;
      default: r = {31'd0, s[31] ^ v};
    endcase
    z = (r == 32'd0);
    o = (c[1:0] == 2'b10) && v;
  endtask

  task automatic t_reset_state;
    #1;
    chk("R2 idle result", res, 32'd0);
    chk("R7 idle zero", {31'd0, zero}, 32'd1);
    chk("R8 idle ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_logic;
    apply(4'b0000, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R2 and", res, 32'hF000_0034);
    apply(4'b0001, 32'hF0F0_1234, 32'hFF00_00FF);
    chk("R2 or", res, 32'hFFF0_12FF);
    chk("R8 or no ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_add;
    apply(4'b0010, 32'd1234, 32'd4321);
    chk("R3 add", res, 32'd5555);
    apply(4'b0010, 32'h7FFF_FFFF, 32'd1);
    chk("R3 add wrap", res, 32'h8000_0000);
    chk("R8 add pos ovf", {31'd0, ovf}, 32'd1);
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
    chk("R8 add neg ovf", {31'd0, ovf}, 32'd1);
    chk("R7 zero on wrap", {31'd0, zero}, 32'd1);
    apply(4'b0010, 32'hFFFF_FFFF, 32'd1);
    chk("R8 carry not ovf", {31'd0, ovf}, 32'd0);
    chk("R7 zero carry", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_sub;
    apply(4'b0110, 32'd100, 32'd58);
    chk("R4 sub", res, 32'd42);
    apply(4'b0110, 32'd5, 32'd9);
    chk("R4 sub neg", res, 32'hFFFF_FFFC);
    chk("R8 sub no ovf", {31'd0, ovf}, 32'd0);
    apply(4'b0110, 32'h8000_0000, 32'd1);
    chk("R8 sub ovf", {31'd0, ovf}, 32'd1);
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    chk("R7 sub equal zero", {31'd0, zero}, 32'd1);
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
    chk("R7 sub unequal", {31'd0, zero}, 32'd0);
  endtask

  task automatic t_slt;
    apply(4'b0111, 32'hFFFF_FFFF, 32'd1);
    chk("R5 slt -1<1", res, 32'd1);
    apply(4'b0111, 32'd1, 32'hFFFF_FFFF);
    chk("R5 slt 1<-1", res, 32'd0);
    apply(4'b0111, 32'h8000_0000, 32'd1);
    chk("R5 slt ovf min<1", res, 32'd1);
    chk("R8 slt no ovf flag", {31'd0, ovf}, 32'd0);
    apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    chk("R5 slt ovf max<min", res, 32'd0);
    chk("R7 slt false zero", {31'd0, zero}, 32'd1);
    apply(4'b0111, 32'd7, 32'd7);
    chk("R5 slt equal", res, 32'd0);
  endtask

  task automatic t_nor;
    apply(4'b1100, 32'h0F0F_0000, 32'h00FF_000F);
    chk("R6 nor", res, 32'hF000_FFF0);
    apply(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF);
    chk("R7 nor zero", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_other_codes;
    apply(4'b0100, 32'hFFFF_0000, 32'hF0F0_F0F0);
    chk("R9 and-not", res, 32'h0F0F_0000);
    apply(4'b1101, 32'hFFFF_0000, 32'hFF00_FF00);
    chk("R9 nand", res, 32'h00FF_FFFF);
    apply(4'b1010, 32'd10, 32'd30);
    chk("R9 nota plus b", res, 32'd19);
  endtask

  task automatic t_random;
    logic [31:0] er;
    logic        ez, eo;
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  c;
      logic [31:0] av, bv;
      c  = 4'(n);
      av = $urandom();
      bv = (n % 7 == 0) ? av : $urandom();
      apply(c, av, bv);
      model(c, av, bv, er, ez, eo);
      chk("R1 random result", res, er);
      chk("R7 random zero", {31'd0, zero}, {31'd0, ez});
      chk("R8 random ovf", {31'd0, ovf}, {31'd0, eo});
    end
  endtask

  initial begin
    t_reset_state();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_nor();
    t_other_codes();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule